// File: doc/BRIEF.md
# Command Ring Wrap and Age Tracker

This block keeps the producer-side bookkeeping for a circular command buffer that a host fills with fixed 20-byte command blocks and a DMA engine drains. It holds the byte offset of the write tail, derives the free space left before the end of the buffer, and keeps a wrap-pending flag and a wrap counter. A flush request either hands the new tail to the engine or, when space has fallen under a high-water mark, opens a wrap back to the buffer start. While a wrap is open, further submissions either finish it (when the engine reports idle) or are turned away with a busy response.

To retire buffers, the block stamps each one with an age made of a wrap count and a head position. A separate comparator tells whether a given age has already been passed by the consumer, ordering ages first by wrap count and then by head position. Every request produces its response one clock after it is sampled.

Top module: `ring_tracker`

## Requirements
- R1: After a synchronous active-low reset the tail is 0, the wrap flag is clear, the wrap counter is 0, free space equals the buffer size, and no response strobe is high.
- R2: An accepted submission of N blocks advances the tail by 20*N bytes, free space becomes buffer size minus tail, and `sub_ok` pulses in the next cycle.
- R3: A flush request with no wrap pending and free space at or above the high-water mark pulses `flush_issue` and leaves tail, flag and counter unchanged.
- R4: A flush request with no wrap pending and free space below the high-water mark pulses `wrap_start` and sets the wrap flag, with the tail unchanged.
- R5: A flush request while a wrap is pending produces no strobe and changes no state.
- R6: A submission while a wrap is pending and `eng_idle` is high completes the wrap: the flag clears, the counter increments, the tail restarts at 0 and then advances by the submitted blocks, and `sub_ok` pulses.
- R7: A submission while a wrap is pending, `eng_idle` is low and free space is below the high-water mark pulses `sub_busy` and leaves the tail, flag and counter unchanged.
- R8: A stamp request with `stamp_dispatched` high returns head = tail + `stamp_base` and wrap = current wrap counter; with it low it returns head 0 and wrap 0; `stamp_valid` pulses in the next cycle and the tail used is the one before any same-cycle submission.
- R9: `retired` is high when `age_wrap` is below the wrap counter, or when they are equal and `age_head` is below `eng_head`; otherwise it is low.
- R10: When a submission and a flush request arrive in the same cycle, only the submission acts and at most one of `sub_ok`, `sub_busy`, `flush_issue`, `wrap_start` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_req | input | 1 | Submit command blocks |
| sub_blocks | input | NBW | Number of 20-byte blocks in the submission |
| eng_idle | input | 1 | DMA engine reports idle |
| flush_req | input | 1 | Flush request |
| stamp_req | input | 1 | Request an age stamp |
| stamp_dispatched | input | 1 | Buffer being stamped was dispatched |
| stamp_base | input | AW | Buffer base offset added to the tail |
| eng_head | input | AW | Consumer's current head position |
| age_wrap | input | WCW | Wrap count of the age under test |
| age_head | input | AW | Head of the age under test |
| sub_ok | output | 1 | Submission accepted |
| sub_busy | output | 1 | Submission refused |
| flush_issue | output | 1 | Ordinary flush of the tail issued |
| wrap_start | output | 1 | Wrap opened |
| stamp_valid | output | 1 | Stamp outputs valid |
| stamp_head | output | AW | Stamped head |
| stamp_wrap | output | WCW | Stamped wrap count |
| retired | output | 1 | Age under test has been passed |
| tail | output | AW | Write tail byte offset |
| space | output | AW | Free bytes to buffer end |
| wrapped | output | 1 | Wrap pending |
| wrap_cnt | output | WCW | Wrap counter |

## Verification
The assertions watch, on every cycle, that the response strobes stay mutually exclusive, that an open wrap blocks flushes and busy submissions from moving the tail, that the wrap counter only moves together with a completed wrap, and that an older wrap count always reads as retired. Only the bench scenarios can show the exact tail and space arithmetic, the stamp values for dispatched and undispatched buffers, the full lexicographic age order including the equal-head case, and a complete high-water-driven wrap round trip.

// File: rtl/ring_tracker.sv
module ring_tracker #(
  parameter int AW        = 16,
  parameter int WCW       = 8,
  parameter int NBW       = 4,
  parameter int SIZE      = 200,
  parameter int HIGH_MARK = 60,
  parameter int BLK_BYTES = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sub_req,
  input  logic [NBW-1:0] sub_blocks,
  input  logic           eng_idle,
  input  logic           flush_req,
  input  logic           stamp_req,
  input  logic           stamp_dispatched,
  input  logic [AW-1:0]  stamp_base,
  input  logic [AW-1:0]  eng_head,
  input  logic [WCW-1:0] age_wrap,
  input  logic [AW-1:0]  age_head,
  output logic           sub_ok,
  output logic           sub_busy,
  output logic           flush_issue,
  output logic           wrap_start,
  output logic           stamp_valid,
  output logic [AW-1:0]  stamp_head,
  output logic [WCW-1:0] stamp_wrap,
  output logic           retired,
  output logic [AW-1:0]  tail,
  output logic [AW-1:0]  space,
  output logic           wrapped,
  output logic [WCW-1:0] wrap_cnt
);
  localparam logic [AW-1:0] SIZE_L = AW'(SIZE);
  localparam logic [AW-1:0] HIGH_L = AW'(HIGH_MARK);
  localparam logic [AW-1:0] BLK_L  = AW'(BLK_BYTES);

  logic [AW-1:0] adv;
  logic          low;

  assign space   = SIZE_L - tail;
  assign low     = space < HIGH_L;
  assign adv     = AW'(sub_blocks) * BLK_L;
  assign retired = (age_wrap < wrap_cnt) ||
                   ((age_wrap == wrap_cnt) && (age_head < eng_head));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail        <= '0;
      wrapped     <= 1'b0;
      wrap_cnt    <= '0;
      sub_ok      <= 1'b0;
      sub_busy    <= 1'b0;
      flush_issue <= 1'b0;
      wrap_start  <= 1'b0;
      stamp_valid <= 1'b0;
      stamp_head  <= '0;
      stamp_wrap  <= '0;
    end else begin
      sub_ok      <= 1'b0;
      sub_busy    <= 1'b0;
      flush_issue <= 1'b0;
      wrap_start  <= 1'b0;
      stamp_valid <= stamp_req;
      if (stamp_req) begin
        stamp_head <= stamp_dispatched ? tail + stamp_base : '0;
        stamp_wrap <= stamp_dispatched ? wrap_cnt : '0;
      end
      if (sub_req) begin
        if (wrapped && eng_idle) begin
          wrapped  <= 1'b0;
          wrap_cnt <= wrap_cnt + 1'b1;
          tail     <= adv;
          sub_ok   <= 1'b1;
        end else if (wrapped && low) begin
          sub_busy <= 1'b1;
        end else begin
          tail   <= tail + adv;
          sub_ok <= 1'b1;
        end
      end else if (flush_req && !wrapped) begin
        if (low) begin
          wrapped    <= 1'b1;
          wrap_start <= 1'b1;
        end else begin
          flush_issue <= 1'b1;
        end
      end
    end
  end
endmodule

module ring_tracker_chk #(
  parameter int AW        = 16,
  parameter int WCW       = 8,
  parameter int NBW       = 4,
  parameter int SIZE      = 200,
  parameter int HIGH_MARK = 60,
  parameter int BLK_BYTES = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sub_req,
  input logic           eng_idle,
  input logic           flush_req,
  input logic [WCW-1:0] age_wrap,
  input logic           sub_ok,
  input logic           sub_busy,
  input logic           flush_issue,
  input logic           wrap_start,
  input logic           retired,
  input logic [AW-1:0]  tail,
  input logic           wrapped,
  input logic [WCW-1:0] wrap_cnt
);
  p_one_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sub_ok, sub_busy, flush_issue, wrap_start}));

  p_wrap_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_start |-> wrapped);

  p_flush_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && flush_req && !sub_req) |=>
      (wrapped && $stable(tail) && !flush_issue && !wrap_start));

  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && sub_req && !eng_idle) |=> (sub_busy && $stable(tail) && wrapped));

  p_wrap_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_cnt != $past(wrap_cnt)) |-> (sub_ok && !wrapped && $past(wrapped)));

  p_old_wrap_retired_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age_wrap < wrap_cnt) |-> retired);
endmodule

bind ring_tracker ring_tracker_chk #(
  .AW(AW), .WCW(WCW), .NBW(NBW), .SIZE(SIZE),
  .HIGH_MARK(HIGH_MARK), .BLK_BYTES(BLK_BYTES)
) u_chk (.*);

// File: tb/ring_tracker_bench.sv
module ring_tracker_bench;
  localparam int AW = 16, WCW = 8, NBW = 4, SIZE = 200, HIGH = 60, BLK = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_req = 0, eng_idle = 0, flush_req = 0, stamp_req = 0, stamp_dispatched = 0;
  logic [NBW-1:0] sub_blocks = '0;
  logic [AW-1:0]  stamp_base = '0, eng_head = '0, age_head = '0;
  logic [WCW-1:0] age_wrap = '0;
  logic sub_ok, sub_busy, flush_issue, wrap_start, stamp_valid, retired, wrapped;
  logic [AW-1:0]  stamp_head, tail, space;
  logic [WCW-1:0] stamp_wrap, wrap_cnt;

  always #5 clk = ~clk;

  ring_tracker #(.AW(AW), .WCW(WCW), .NBW(NBW), .SIZE(SIZE), .HIGH_MARK(HIGH),
                 .BLK_BYTES(BLK)) u_ring_tracker (.*);

  typedef struct {
    logic [4:0] code;
    int tl; bit wr; int wc; int sh; int sw; int rid;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  int m_tail = 0, m_wc = 0;
  bit m_wr = 0;

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic [4:0] got;
      e = q.pop_front();
      got = {sub_ok, sub_busy, flush_issue, wrap_start, stamp_valid};
      checks++;
      if (got !== e.code || int'(tail) != e.tl || wrapped !== e.wr || int'(wrap_cnt) != e.wc ||
          int'(space) != SIZE - e.tl ||
          (e.code[0] && (int'(stamp_head) != e.sh || int'(stamp_wrap) != e.sw))) begin
        fails++;
        $display("FAIL R%0d: got code=%b tail=%0d wr=%0b wc=%0d sh=%0d sw=%0d exp code=%b tail=%0d wr=%0b wc=%0d sh=%0d sw=%0d",
                 e.rid, got, tail, wrapped, wrap_cnt, stamp_head, stamp_wrap,
                 e.code, e.tl, e.wr, e.wc, e.sh, e.sw);
      end
    end
  end

  task automatic op(input bit s, input int n, input bit idle, input bit f,
                    input bit st, input bit disp, input int base, input int rid);
    exp_t e;
    @(negedge clk);
    sub_req = s; sub_blocks = NBW'(n); eng_idle = idle; flush_req = f;
    stamp_req = st; stamp_dispatched = disp; stamp_base = AW'(base);
    e.code = '0; e.sh = 0; e.sw = 0; e.rid = rid;
    if (st) begin
      e.code[0] = 1'b1;
      e.sh = disp ? m_tail + base : 0;
      e.sw = disp ? m_wc : 0;
    end
    if (s) begin
      if (m_wr && idle) begin
        m_wr = 0; m_wc++; m_tail = n * BLK; e.code[4] = 1'b1;
      end else if (m_wr && (SIZE - m_tail) < HIGH) begin
        e.code[3] = 1'b1;
      end else begin
        m_tail += n * BLK; e.code[4] = 1'b1;
      end
    end else if (f && !m_wr) begin
      if ((SIZE - m_tail) < HIGH) begin m_wr = 1; e.code[1] = 1'b1; end
      else e.code[2] = 1'b1;
    end
    e.tl = m_tail; e.wr = m_wr; e.wc = m_wc;
    q.push_back(e);
    @(negedge clk);
    sub_req = 0; flush_req = 0; stamp_req = 0;
  endtask

  task automatic chk_ret(input int w, input int h, input int eh, input bit exp_r);
    @(negedge clk);
    age_wrap = WCW'(w); age_head = AW'(h); eng_head = AW'(eh);
    #1;
    checks++;
    if (retired !== exp_r) begin
      fails++;
      $display("FAIL R9: age(%0d,%0d) head=%0d got %0b exp %0b", w, h, eh, retired, exp_r);
    end
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (tail !== 0 || wrapped !== 0 || wrap_cnt !== 0 || space !== AW'(SIZE) ||
        {sub_ok, sub_busy, flush_issue, wrap_start, stamp_valid} !== 5'b0) begin
      fails++;
      $display("FAIL R1: tail=%0d wr=%0b wc=%0d space=%0d exp 0 0 0 %0d", tail, wrapped, wrap_cnt, space, SIZE);
    end
    rst_n = 1'b1;
    op(1, 3, 0, 0, 0, 0, 0, 2);          // R2 tail 60
    op(0, 0, 0, 1, 0, 0, 0, 3);          // R3 ordinary flush
    op(0, 0, 0, 0, 1, 1, 'h1000, 8);     // R8 dispatched stamp
    op(0, 0, 0, 0, 1, 0, 'h1000, 8);     // R8 undispatched stamp
    op(1, 5, 0, 0, 0, 0, 0, 2);          // R2 tail 160 space 40
    op(0, 0, 0, 1, 0, 0, 0, 4);          // R4 wrap opens
    op(0, 0, 1, 1, 0, 0, 0, 5);          // R5 flush ignored
    op(1, 1, 0, 0, 0, 0, 0, 7);          // R7 busy refusal
    op(1, 2, 0, 1, 0, 0, 0, 7);          // R7 busy, flush also ignored
    op(1, 2, 1, 0, 1, 1, 'h20, 6);       // R6 wrap completes, R8 old tail stamped
    op(0, 0, 0, 0, 1, 1, 0, 8);          // R8 stamp after wrap: head 40 wrap 1
    op(1, 1, 0, 1, 0, 0, 0, 10);         // R10 submit wins over flush
    chk_ret(0, 500, 10, 1);              // R9 older wrap
    chk_ret(1, 30, 40, 1);               // R9 same wrap, lower head
    chk_ret(1, 40, 40, 0);               // R9 equal head
    chk_ret(2, 0, 40, 0);                // R9 newer wrap
    op(1, 7, 0, 0, 0, 0, 0, 2);          // R2 tail 200 space 0
    op(0, 0, 0, 1, 0, 0, 0, 4);          // R4 second wrap
    op(1, 0, 1, 0, 0, 0, 0, 6);          // R6 wrap count 2, tail 0
    chk_ret(1, 900, 0, 1);               // R9 after second wrap
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule